// File: doc/BRIEF.md
# Port-space I/O decoder with shared register bank

This block sits between a processor bus and a small bank of peripheral registers, where the registers live in an I/O address space of their own beside main memory. The processor reaches that space with a pair of dedicated I/O strobes. When either strobe is high, the block claims the access as a port access and drops the memory chip-select. Otherwise memory owns the bus. Main memory itself is outside the block; only its chip-select is produced here.

Port decoding looks at the low twelve address lines only. A parameterised window of consecutive port addresses is backed by real 16-bit registers, and the decoder raises exactly one select line for the addressed register. Every register can also be read and written by the peripheral through a separate index-based port. A read of an unbacked port address returns zero, and a write to one is dropped. When both sides write the same register on the same edge, the processor write is kept. When both I/O strobes are high together, the access is flagged as an error and no processor write takes place.

Top module: `port_io_decoder`

## Requirements
- R1: `port_sel` is high exactly when `io_rd` or `io_wr` is high.
- R2: `mem_cs` is the inverse of `port_sel`, so memory and ports never answer the same access.
- R3: Only `cpu_addr[11:0]` takes part in port decoding; bits 23..12 have no effect on which register a port access reaches.
- R4: Port addresses `PORT_BASE` to `PORT_BASE+NUM_REGS-1` (0x280 to 0x287 by default) are backed. During a port access to one of them, `reg_sel` bit (address minus `PORT_BASE`) is high and all other bits are low. Outside that window, or with no port access, `reg_sel` is all zero. Reads of unbacked addresses return 0, and writes to them change nothing.
- R5: A port write (`io_wr` high, `io_rd` low) to a backed address stores the 16-bit `cpu_wdata` at the next rising clock edge.
- R6: `per_rdata` shows the register selected by `per_idx` without a clock delay. `per_we` stores `per_wdata` into that register at the next rising edge.
- R7: When the processor and the peripheral write the same register on the same edge, the processor value is stored. Writes to different registers on the same edge both take effect.
- R8: `cpu_rdata` carries the addressed register only while `io_rd` is high and `io_wr` is low. At all other times it is zero.
- R9: When `io_rd` and `io_wr` are both high, `io_err` is high, no processor write happens, and `cpu_rdata` is zero. A peripheral write in that same cycle still takes effect.
- R10: A synchronous active-low reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 24 | Processor address bus |
| cpu_wdata | input | 16 | Processor write data |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| cpu_rdata | output | 16 | Port read data toward the processor |
| port_sel | output | 1 | Access targets port space |
| mem_cs | output | 1 | Chip-select for main memory |
| io_err | output | 1 | Both I/O strobes high at once |
| reg_sel | output | 8 | One-hot select of the addressed register |
| per_idx | input | 3 | Peripheral register index |
| per_we | input | 1 | Peripheral write enable |
| per_wdata | input | 16 | Peripheral write data |
| per_rdata | output | 16 | Register contents at `per_idx` |

## Verification
Register contents are the only internal state. A corrupted value shows up on `per_rdata` within the same cycle once the peripheral index points at it, and on `cpu_rdata` as soon as a port read addresses it. For that reason, every write in the stimulus is followed by a readback on both sides.

A write that lands in the wrong register, survives an error cycle, or loses a conflict it should win is seen one clock after the offending edge. The decode outputs are combinational, so a decode fault shows on `port_sel`, `mem_cs` and `reg_sel` in the same cycle as the access.

// File: rtl/pio_pkg.sv
// Shared definitions for the port-space I/O decoder.
// Assumes active-high I/O strobes on the processor side.
package pio_pkg;

    // Classification of one bus cycle by its I/O strobes.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_READ  = 2'b10,
        ACC_CLASH = 2'b11
    } io_access_e;

endpackage

// File: rtl/pio_addr_decode.sv
// Address and strobe decoder.
// Classifies the bus cycle, derives the port and memory selects, and decodes
// the low port address lines into a one-hot register select and a write vector.
// Assumes the backed window fits inside the PORT_AW-bit port space.
module pio_addr_decode
    import pio_pkg::*;
#(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned PORT_AW   = 12,
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned PORT_BASE = 'h280,
    localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                io_rd,
    input  logic                io_wr,
    output logic                port_sel,
    output logic                mem_cs,
    output logic                io_err,
    output logic                rd_en,
    output logic                hit,
    output logic [IDX_W-1:0]    idx,
    output logic [NUM_REGS-1:0] sel,
    output logic [NUM_REGS-1:0] cpu_we
);

    localparam logic [PORT_AW:0] LO_BOUND = (PORT_AW+1)'(PORT_BASE);
    localparam logic [PORT_AW:0] HI_BOUND = (PORT_AW+1)'(PORT_BASE + NUM_REGS);

    io_access_e       acc;
    logic [PORT_AW:0] lo_ext;
    logic [PORT_AW:0] offset;

    // Classify the cycle by its strobes.
    always_comb begin
        acc = io_access_e'({io_rd, io_wr});
    end

    // Derive the selects and the window hit from the low address lines.
    always_comb begin
        port_sel = (acc != ACC_IDLE);
        mem_cs   = (acc == ACC_IDLE);
        io_err   = (acc == ACC_CLASH);
        rd_en    = (acc == ACC_READ);
        lo_ext   = {1'b0, addr[PORT_AW-1:0]};
        offset   = lo_ext - LO_BOUND;
        hit      = (lo_ext >= LO_BOUND) && (lo_ext < HI_BOUND);
        idx      = offset[IDX_W-1:0];
    end

    // One select and one write enable per backed register.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        always_comb begin
            sel[i]    = port_sel && hit && (idx == IDX_W'(i));
            cpu_we[i] = sel[i] && (acc == ACC_WRITE);
        end
    end

endmodule

// File: rtl/pio_dual_reg_bank.sv
// Bank of registers written from two sides.
// The processor side uses a one-hot write vector and the peripheral side an index.
// When both hit the same register on one edge, the processor write is kept.
// Assumes cpu_we has at most one bit set.
module pio_dual_reg_bank #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0]              cpu_we,
    input  logic [DATA_W-1:0]                cpu_wdata,
    input  logic                             per_we,
    input  logic [IDX_W-1:0]                 per_idx,
    input  logic [DATA_W-1:0]                per_wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic per_hit;

        // Peripheral write aimed at this register.
        always_comb begin
            per_hit = per_we && (per_idx == IDX_W'(i));
        end

        // Update this register; the processor side has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= '0;
            else if (cpu_we[i])
                q[i] <= cpu_wdata;
            else if (per_hit)
                q[i] <= per_wdata;
        end

        assert_cpu_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_we[i] |=> q[i] == $past(cpu_wdata));

        assert_cpu_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_we[i] && per_hit) |=> q[i] != $past(per_wdata) || $past(per_wdata) == $past(cpu_wdata));

        assert_per_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (per_hit && !cpu_we[i]) |=> q[i] == $past(per_wdata));
    end

endmodule

// File: rtl/port_io_decoder.sv
// Top level of the port-space I/O decoder.
// Decodes the processor access, steers writes into the shared register bank,
// and drives the read buses for the processor and the peripheral.
// Assumes the processor strobes are synchronous to clk.
module port_io_decoder #(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned PORT_AW   = 12,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned PORT_BASE = 'h280,
    localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic                io_rd,
    input  logic                io_wr,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                port_sel,
    output logic                mem_cs,
    output logic                io_err,
    output logic [NUM_REGS-1:0] reg_sel,
    input  logic [IDX_W-1:0]    per_idx,
    input  logic                per_we,
    input  logic [DATA_W-1:0]   per_wdata,
    output logic [DATA_W-1:0]   per_rdata
);

    logic                            rd_en;
    logic                            hit;
    logic [IDX_W-1:0]                idx;
    logic [NUM_REGS-1:0]             cpu_we;
    logic [NUM_REGS-1:0][DATA_W-1:0] q;

    pio_addr_decode #(
        .ADDR_W   (ADDR_W),
        .PORT_AW  (PORT_AW),
        .NUM_REGS (NUM_REGS),
        .PORT_BASE(PORT_BASE)
    ) i_dec (
        .addr    (cpu_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .port_sel(port_sel),
        .mem_cs  (mem_cs),
        .io_err  (io_err),
        .rd_en   (rd_en),
        .hit     (hit),
        .idx     (idx),
        .sel     (reg_sel),
        .cpu_we  (cpu_we)
    );

    pio_dual_reg_bank #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_we   (cpu_we),
        .cpu_wdata(cpu_wdata),
        .per_we   (per_we),
        .per_idx  (per_idx),
        .per_wdata(per_wdata),
        .q        (q)
    );

    // Processor read bus: the addressed register during a clean read, else zero.
    always_comb begin
        cpu_rdata = '0;
        if (rd_en && hit)
            cpu_rdata = q[idx];
    end

    // Peripheral read bus; a guard is needed only when the index can overrun.
    if (NUM_REGS == (1 << IDX_W)) begin : g_per_full
        always_comb begin
            per_rdata = q[per_idx];
        end
    end else begin : g_per_guard
        always_comb begin
            per_rdata = '0;
            if (32'(per_idx) < NUM_REGS)
                per_rdata = q[per_idx];
        end
    end

    assert_sel_needs_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !port_sel |-> reg_sel == '0);

    assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_sel));

    assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> cpu_rdata == '0);

    assert_err_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_err && !per_we) |=> $stable(q));

    assert_mem_port_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> !mem_cs);

endmodule

// File: tb/test_port_io_decoder.sv
// Bench for port_io_decoder: a vector table walked by one loop, then directed
// tests for reset and corner cases. Inputs change at the falling edge and
// outputs are sampled 1 ns later.
module test_port_io_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] cpu_addr;
    logic [15:0] cpu_wdata;
    logic        io_rd, io_wr;
    logic [15:0] cpu_rdata;
    logic        port_sel, mem_cs, io_err;
    logic [7:0]  reg_sel;
    logic [2:0]  per_idx;
    logic        per_we;
    logic [15:0] per_wdata;
    logic [15:0] per_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    port_io_decoder i_port_io_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .cpu_rdata(cpu_rdata), .port_sel(port_sel),
        .mem_cs(mem_cs), .io_err(io_err), .reg_sel(reg_sel), .per_idx(per_idx),
        .per_we(per_we), .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    // Fields: rd, wr, addr, wdata, pwe, pidx, pwdata, exp_rdata, exp_per, exp_psel, exp_err
    localparam int NV = 18;
    localparam logic [95:0] VEC [NV] = '{
        {1'b0,1'b1,24'h000280,16'h1111,1'b0,3'd0,16'h0000,16'h0000,16'h0000,1'b1,1'b0}, // R5 write
        {1'b1,1'b0,24'h000280,16'h0000,1'b0,3'd0,16'h0000,16'h1111,16'h1111,1'b1,1'b0}, // R5 readback
        {1'b1,1'b0,24'hABC280,16'h0000,1'b0,3'd1,16'h0000,16'h1111,16'h0000,1'b1,1'b0}, // R3 alias
        {1'b1,1'b0,24'h000288,16'h0000,1'b0,3'd0,16'h0000,16'h0000,16'h1111,1'b1,1'b0}, // R4 unbacked
        {1'b0,1'b1,24'h000288,16'hDEAD,1'b0,3'd7,16'h0000,16'h0000,16'h0000,1'b1,1'b0}, // R4 dropped
        {1'b0,1'b0,24'h000280,16'h0000,1'b0,3'd0,16'h0000,16'h0000,16'h1111,1'b0,1'b0}, // R8 idle
        {1'b0,1'b0,24'h000000,16'h0000,1'b1,3'd3,16'h3333,16'h0000,16'h0000,1'b0,1'b0}, // R6 write
        {1'b1,1'b0,24'h000283,16'h0000,1'b0,3'd3,16'h0000,16'h3333,16'h3333,1'b1,1'b0}, // R6 readback
        {1'b0,1'b1,24'h000283,16'hAAAA,1'b1,3'd3,16'h5555,16'h0000,16'h3333,1'b1,1'b0}, // R7 clash
        {1'b1,1'b0,24'h000283,16'h0000,1'b0,3'd3,16'h0000,16'hAAAA,16'hAAAA,1'b1,1'b0}, // R7 cpu kept
        {1'b0,1'b1,24'h000284,16'h4444,1'b1,3'd5,16'h5555,16'h0000,16'h0000,1'b1,1'b0}, // R7 two regs
        {1'b1,1'b0,24'h000285,16'h0000,1'b0,3'd4,16'h0000,16'h5555,16'h4444,1'b1,1'b0}, // R7 both kept
        {1'b1,1'b1,24'h000284,16'hFFFF,1'b0,3'd4,16'h0000,16'h0000,16'h4444,1'b1,1'b1}, // R9 clash
        {1'b1,1'b0,24'h000284,16'h0000,1'b0,3'd4,16'h0000,16'h4444,16'h4444,1'b1,1'b0}, // R9 no write
        {1'b0,1'b1,24'h000287,16'h7777,1'b0,3'd7,16'h0000,16'h0000,16'h0000,1'b1,1'b0}, // R4 top edge
        {1'b1,1'b0,24'h000287,16'h0000,1'b0,3'd7,16'h0000,16'h7777,16'h7777,1'b1,1'b0}, // R4 top read
        {1'b1,1'b0,24'h00027F,16'h0000,1'b0,3'd2,16'h0000,16'h0000,16'h0000,1'b1,1'b0}, // R4 below
        {1'b1,1'b0,24'h000FFF,16'h0000,1'b0,3'd0,16'h0000,16'h0000,16'h1111,1'b1,1'b0}  // R4 far end
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Model of R4: expected one-hot select from strobes and address.
    function automatic logic [7:0] model_sel(input logic psel, input logic [23:0] a);
        logic [11:0] lo = a[11:0];
        if (psel && lo >= 12'h280 && lo < 12'h288)
            return 8'(1 << (lo - 12'h280));
        return 8'h00;
    endfunction

    task automatic drive(input logic rd, input logic wr, input logic [23:0] a,
                         input logic [15:0] wd, input logic pwe, input logic [2:0] pi,
                         input logic [15:0] pwd);
        io_rd = rd; io_wr = wr; cpu_addr = a; cpu_wdata = wd;
        per_we = pwe; per_idx = pi; per_wdata = pwd;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 24'h0, 16'h0, 1'b0, 3'd0, 16'h0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: every register reads zero after reset.
        for (int k = 0; k < 8; k++) begin
            per_idx = 3'(k);
            #1 check("R10", per_rdata, 16'h0000);
        end
        #1 check("R8", cpu_rdata, 16'h0000);
        check("R2", {15'b0, mem_cs}, 16'h0001);

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            drive(VEC[v][95], VEC[v][94], VEC[v][93:70], VEC[v][69:54],
                  VEC[v][53], VEC[v][52:50], VEC[v][49:34]);
            #1;
            check("R8", cpu_rdata, VEC[v][33:18]);
            check("R6", per_rdata, VEC[v][17:2]);
            check("R1", {15'b0, port_sel}, {15'b0, VEC[v][1]});
            check("R2", {15'b0, mem_cs}, {15'b0, ~VEC[v][1]});
            check("R9", {15'b0, io_err}, {15'b0, VEC[v][0]});
            check("R4", {8'b0, reg_sel}, {8'b0, model_sel(VEC[v][1], VEC[v][93:70])});
        end

        // R9: an error cycle still lets the peripheral write through.
        @(negedge clk);
        drive(1'b1, 1'b1, 24'h000286, 16'h1234, 1'b1, 3'd6, 16'h6666);
        #1 check("R9", {15'b0, io_err}, 16'h0001);
        check("R9", cpu_rdata, 16'h0000);
        @(negedge clk);
        drive(1'b1, 1'b0, 24'h000286, 16'h0000, 1'b0, 3'd6, 16'h0000);
        #1 check("R9", cpu_rdata, 16'h6666);

        // R3: a write with high address bits set reaches the same register.
        @(negedge clk);
        drive(1'b0, 1'b1, 24'hFFF281, 16'hBEEF, 1'b0, 3'd1, 16'h0000);
        @(negedge clk);
        drive(1'b0, 1'b0, 24'h000000, 16'h0000, 1'b0, 3'd1, 16'h0000);
        #1 check("R3", per_rdata, 16'hBEEF);

        // R10: reset in mid-run clears stored values.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        drive(1'b1, 1'b0, 24'h000283, 16'h0000, 1'b0, 3'd1, 16'h0000);
        #1 check("R10", cpu_rdata, 16'h0000);
        check("R10", per_rdata, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule